// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block owns the programming state of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test select. It accepts that state from two sources. One is a parallel word qualified by an active-low load strobe. The other is a serial bit stream with its own data pin, shift clock and load strobe. Its outputs are the effective values that the divider logic uses.

All strobe, clock and data pins are asynchronous to the system clock. They pass through equal-depth synchronisers, so a data bit stays aligned with the strobe or clock that qualifies it. Edges are taken from the synchronised copies, and every register in the block runs on one clock.

A parallel strobe held low is a transparent window: the pins flow to the outputs and the test select reads zero. Raising the strobe freezes the pins. With the parallel strobe high, the serial load pin picks the behaviour. When it is low, the shift clock fills a 14-bit shift register and the outputs stay as they are. When it is high, the shift register shows directly on the outputs and further shifts show up at once. Its falling edge freezes what was shown.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `par_load_n` is low, `m_val` and `n_code` follow `par_m` and `par_n`, and `t_sel` reads 000.
- R2: On the rising edge of `par_load_n`, the pin values are captured. Later pin changes have no effect on the outputs while the serial path stays idle.
- R3: With `par_load_n` high and `ser_load` low, each rising `ser_clk` shifts `ser_data` into the shift register. The outputs do not change.
- R4: The frame is 14 bits and the first bit sent is the MSB. While `ser_load` is high (and `par_load_n` high), `t_sel` = register bits 13:11, `n_code` = bits 10:9 and `m_val` = bits 8:0. In sending order the bits are T2, T1, T0, N1, N0, M8 down to M0.
- R5: On the falling edge of `ser_load`, the shown values are latched. Shifts made afterwards with `ser_load` low leave the outputs unchanged.
- R6: While `ser_load` stays high, each rising `ser_clk` moves the register up by one and puts `ser_data` at bit 0. The outputs follow each step.
- R7: Shift clocks that arrive while `par_load_n` is low leave the shift register untouched.
- R8: A low `par_load_n` takes priority over a high `ser_load`.
- R9: After reset, `m_val` = 9'h1FF, `n_code` = 2'b11 and `t_sel` = 3'b000.
- R10: `cfg_updated` pulses for exactly one cycle each time `m_val` or `n_code` changes. It stays low when only `t_sel` changes or when nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel strobe, low = transparent |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| m_val | output | 9 | Effective feedback divide value |
| n_code | output | 2 | Effective output divide code |
| t_sel | output | 3 | Effective test select |
| cfg_updated | output | 1 | One-cycle pulse on an M or N change |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2. This checks that data and strobes stay aligned through a deeper synchroniser, and that no output glitch appears on a strobe edge. The scoreboard also counts `cfg_updated` pulses between checks, so a stray intermediate value would show up as an extra pulse.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;

  // Field order matches the serial frame: first-sent bits sit at the top.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{t: '0, n: '1, m: '1};
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pl_s,
  input  logic sck_rise,
  input  logic sd_s,
  output cfg_t sr_q
);
  logic [FRAME_W-1:0] bits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                bits <= FRAME_W'(CFG_RESET);
    else if (pl_s && sck_rise) bits <= {bits[FRAME_W-2:0], sd_s};

  assign sr_q = cfg_t'(bits);

  // R7
  shift_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> $stable(bits));
endmodule

// File: rtl/cfg_select.sv
module cfg_select
  import synth_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pl_s,
  input  logic pl_rise,
  input  logic sl_s,
  input  logic sl_fall,
  input  cfg_t par_cfg,
  input  cfg_t sr_cfg,
  output cfg_t eff,
  output logic upd
);
  cfg_t held, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                held <= CFG_RESET;
    else if (pl_rise)          held <= par_cfg;
    else if (pl_s && sl_fall)  held <= sr_cfg;

  always_comb begin
    if (!pl_s || pl_rise)     nxt = par_cfg;
    else if (sl_s || sl_fall) nxt = sr_cfg;
    else                      nxt = held;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      eff <= CFG_RESET;
      upd <= 1'b0;
    end else begin
      eff <= nxt;
      upd <= (nxt.m != eff.m) || (nxt.n != eff.n);
    end

  // R2
  par_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_rise |=> held == $past(par_cfg));
  // R5
  ser_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && sl_fall && !pl_rise) |=> held == $past(sr_cfg));
  // R10
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (eff.m != $past(eff.m)) || (eff.n != $past(eff.n)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           cfg_updated
);
  localparam int          DAT_W   = M_W + N_W + 1;
  localparam logic [2:0]  CTL_RST = 3'b001;

  logic [2:0]       ctl_s, ctl_q;
  logic [DAT_W-1:0] dat_s;
  logic pl_s, sck_s, sl_s, pl_rise, sck_rise, sl_fall, sd_s;
  cfg_t par_cfg, sr_cfg, eff;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_load, ser_clk, par_load_n}), .q(ctl_s));

  cfg_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_data, par_n, par_m}), .q(dat_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_s;

  assign pl_s     = ctl_s[0];
  assign sck_s    = ctl_s[1];
  assign sl_s     = ctl_s[2];
  assign pl_rise  = pl_s  & ~ctl_q[0];
  assign sck_rise = sck_s & ~ctl_q[1];
  assign sl_fall  = ~sl_s & ctl_q[2];
  assign sd_s     = dat_s[DAT_W-1];

  always_comb begin
    par_cfg.t = '0;
    par_cfg.n = dat_s[M_W +: N_W];
    par_cfg.m = dat_s[M_W-1:0];
  end

  cfg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sck_rise(sck_rise),
    .sd_s(sd_s), .sr_q(sr_cfg));

  cfg_select u_sel (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .pl_rise(pl_rise),
    .sl_s(sl_s), .sl_fall(sl_fall), .par_cfg(par_cfg), .sr_cfg(sr_cfg),
    .eff(eff), .upd(cfg_updated));

  assign m_val  = eff.m;
  assign n_code = eff.n;
  assign t_sel  = eff.t;

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> (t_sel == '0) && (m_val == $past(par_cfg.m)) && (n_code == $past(par_cfg.n)));
  // R8
  par_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_s && sl_s) |=> t_sel == '0);
endmodule

// File: tb/tb_synth_cfg_loader.sv
`timescale 1ns/1ps
module tb_synth_cfg_loader;
  logic       clk = 0, rst_n = 0;
  logic       par_load_n = 1, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_sel;
  logic       cfg_updated;

  int checks = 0, errors = 0, pulses = 0, pulses_seen = 0;
  bit done = 0;
  logic [14:0] exp_q [$];
  string       req_q [$];
  logic [8:0]  last_m = 9'h1FF;
  logic [1:0]  last_n = 2'b11;
  logic [13:0] exp_sr = {3'b000, 11'h7FF};

  always #2.5 clk = ~clk;

  synth_cfg_loader #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .cfg_updated(cfg_updated));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: counts update pulses, pops expected items and compares.
  initial forever begin
    @(negedge clk);
    if (cfg_updated) pulses++;
    if (exp_q.size() > 0) begin
      logic [14:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ({t_sel, n_code, m_val} !== e[13:0]) begin
        errors++;
        $display("FAIL %s: t/n/m actual %h/%h/%h expected %h/%h/%h", r,
                 t_sel, n_code, m_val, e[13:11], e[10:9], e[8:0]);
      end
      checks++;
      if ((pulses - pulses_seen) != int'(e[14])) begin
        errors++;
        $display("FAIL R10 (%s): update pulses actual %0d expected %0d", r,
                 pulses - pulses_seen, e[14]);
      end
      pulses_seen = pulses;
    end
  end

  task automatic expect_cfg(input logic [8:0] m, input logic [1:0] n,
                            input logic [2:0] t, input string req);
    logic p;
    repeat (10) @(negedge clk);
    p = (m != last_m) || (n != last_n);
    exp_q.push_back({p, t, n, m});
    req_q.push_back(req);
    last_m = m;
    last_n = n;
    repeat (3) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1;
    if (par_load_n) exp_sr = {exp_sr[12:0], b};
    repeat (5) @(negedge clk);
    ser_clk = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic ser_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    expect_cfg(9'h1FF, 2'b11, 3'b000, "R9 reset");
    // R1: transparent window
    par_m = 9'h0C8; par_n = 2'b01; par_load_n = 0;
    expect_cfg(9'h0C8, 2'b01, 3'b000, "R1 pass");
    par_m = 9'h0A5; par_n = 2'b10;
    expect_cfg(9'h0A5, 2'b10, 3'b000, "R1 follow");
    // R2: capture on rise, hold afterwards
    par_load_n = 1;
    expect_cfg(9'h0A5, 2'b10, 3'b000, "R2 capture");
    par_m = 9'h111; par_n = 2'b00;
    expect_cfg(9'h0A5, 2'b10, 3'b000, "R2 hold");
    // R3: shift a frame with serial load low
    ser_frame({3'b101, 2'b10, 9'h15E});
    expect_cfg(9'h0A5, 2'b10, 3'b000, "R3 shift hidden");
    // R4: serial load high shows the frame fields
    ser_load = 1;
    expect_cfg(9'h15E, 2'b10, 3'b101, "R4 frame order");
    // R5: latch on falling serial load, then more shifts stay hidden
    ser_load = 0;
    expect_cfg(9'h15E, 2'b10, 3'b101, "R5 latch");
    ser_bit(1); ser_bit(0); ser_bit(1);
    expect_cfg(9'h15E, 2'b10, 3'b101, "R5 hold after shift");
    ser_load = 1;
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R4 shown register");
    // R6: direct pass while serial load held high
    ser_bit(0);
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R6 step 1");
    ser_bit(1);
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R6 step 2");
    // R8: parallel low overrides serial load high
    par_load_n = 0;
    expect_cfg(9'h111, 2'b00, 3'b000, "R8 priority");
    // R7: shifts during parallel window are ignored
    ser_bit(1); ser_bit(1); ser_bit(0); ser_bit(1);
    expect_cfg(9'h111, 2'b00, 3'b000, "R7 outputs");
    par_load_n = 1;
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R7 register untouched");
    ser_load = 0;
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R5 latch again");
    // R10: only T changes -> no pulse
    par_m = exp_sr[8:0]; par_n = exp_sr[10:9];
    expect_cfg(exp_sr[8:0], exp_sr[10:9], exp_sr[13:11], "R2 pins ignored");
    par_load_n = 0;
    expect_cfg(exp_sr[8:0], exp_sr[10:9], 3'b000, "R10 T-only change");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule